// File: doc/BRIEF.md
# Wishbone Window Decoder with Dense and Narrow Lanes

This block sits between one Wishbone initiator and a fixed set of subordinates. Each subordinate owns an address window whose base and power-of-two size are set at elaboration time, with the base aligned to the size. A request that falls inside a window is forwarded to that subordinate only, with the address reduced to an offset within the window. The selected subordinate's acknowledge, error and read data are routed back. Addresses on the initiator side count whole words; byte lanes are picked by the select bus, whose width is the data width divided by the granularity.

A window is either dense or narrow. A dense subordinate has the full data width and sees the data, select and write-enable unchanged. A narrow subordinate has a port that is only `NARROW_W` bits wide, and its granularity equals that width. Each wide word at offset k maps to narrow location k and carries its data in the lowest lane. The narrow device therefore appears on the wide side as a sparse range, with one usable lane in every word.

Handshake and back-pressure follow Wishbone classic cycles. `cyc` together with `stb` is the valid signal. `ack` or `err` from the routed side is the ready signal. The initiator must hold address, data and select stable until it sees one of them. A subordinate stalls the initiator by withholding `ack`. An access that hits no window is answered with a one-cycle `err` when `HAS_ERR` is 1, and is never answered when it is 0.

Top module: `wb_window_decoder`

## Requirements
- R1: A request whose word address lies in window i (default windows: 0 = 0x0000..0x00FF dense, 1 = 0x0100..0x010F narrow, 2 = 0x1000..0x1FFF dense) raises cyc and stb on subordinate i. The subordinate's address is the request address with the bits above the window size cleared.
- R2: At most one subordinate sees cyc at any time. Every subordinate not selected has cyc and stb low.
- R3: A dense window passes dat_w, sel and we unchanged and returns the subordinate's full dat_r.
- R4: A narrow window drives dat_w bits NARROW_W-1:0 with the upper bits zero. It drives sel bits 0 to NARROW_W/GRAN-1 from the request, with the upper sel bits zero. It returns only dat_r bits NARROW_W-1:0 to the initiator, with all upper bits zero, whatever the subordinate drives there.
- R5: The initiator's ack and err follow the selected subordinate only. ack and err from subordinates that are not selected have no effect.
- R6: A request that hits no window reaches no subordinate and is never acknowledged. With HAS_ERR = 1, err rises for exactly one cycle at the clock edge after the request is presented.
- R7: While the initiator's cyc is low, no subordinate sees cyc or stb and ack stays low, even if stb is high.
- R8: After reset, err is low and no request is in flight.
- R9: With HAS_ERR = 0, a request that hits no window gets neither ack nor err, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_adr | input | AW | Initiator word address |
| t_dat_w | input | DW | Initiator write data |
| t_dat_r | output | DW | Read data routed back to the initiator |
| t_sel | input | DW/GRAN | Initiator byte-lane select |
| t_cyc | input | 1 | Initiator cycle in progress |
| t_stb | input | 1 | Initiator strobe (request valid) |
| t_we | input | 1 | Initiator write enable |
| t_ack | output | 1 | Acknowledge to the initiator |
| t_err | output | 1 | Error to the initiator |
| s_adr | output | N_SUB*AW | Per-subordinate window offset |
| s_dat_w | output | N_SUB*DW | Per-subordinate write data |
| s_dat_r | input | N_SUB*DW | Per-subordinate read data |
| s_sel | output | N_SUB*(DW/GRAN) | Per-subordinate select |
| s_cyc | output | N_SUB | Per-subordinate cycle |
| s_stb | output | N_SUB | Per-subordinate strobe |
| s_we | output | N_SUB | Per-subordinate write enable |
| s_ack | input | N_SUB | Per-subordinate acknowledge |
| s_err | input | N_SUB | Per-subordinate error |

## Verification
The main routing function is driven with addresses at the first and last word of every window, and with addresses just past a window and in the gap between windows. These patterns separate a correct size mask from an off-by-one or a base match that is too loose. Writes to the narrow window use select patterns with the low lane on and with it off, and data with nonzero upper bytes. Its subordinate drives garbage on the upper read bits, so any lane leakage in either direction becomes visible. Directed cases hold ack and err high on subordinates that are not selected, hold stb high without cyc, and hold a missed request for several cycles on a second instance built without err.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;
  localparam int LOG2_W = 5;

  // True when adr falls in the power-of-two window starting at base.
  function automatic logic in_window(logic [31:0] adr, logic [31:0] base,
                                     logic [LOG2_W-1:0] lg);
    logic [31:0] diff;
    diff = (adr ^ base) >> lg;
    return diff == 32'd0;
  endfunction
endpackage

// File: rtl/wbdec_match.sv
module wbdec_match
  import wbdec_pkg::*;
#(
  parameter int N_SUB = 3,
  parameter int AW = 16,
  parameter logic [N_SUB*AW-1:0] WIN_BASE = '0,
  parameter logic [N_SUB*LOG2_W-1:0] WIN_LOG2 = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     adr,
  output logic [N_SUB-1:0]  hit,
  output logic [N_SUB*AW-1:0] offset
);
  localparam int PAD = 32 - AW;

  for (genvar i = 0; i < N_SUB; i++) begin : g_win
    localparam logic [LOG2_W-1:0] LG = WIN_LOG2[i*LOG2_W +: LOG2_W];
    localparam logic [AW-1:0] BASE = WIN_BASE[i*AW +: AW];
    localparam logic [31:0] MASK32 = (32'd1 << LG) - 32'd1;
    localparam logic [AW-1:0] MASK = MASK32[AW-1:0];

    assign hit[i] = in_window({{PAD{1'b0}}, adr}, {{PAD{1'b0}}, BASE}, LG);
    assign offset[i*AW +: AW] = adr & MASK;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R2
endmodule

// File: rtl/wbdec_lane.sv
module wbdec_lane #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int GRAN = 8,
  parameter int NARROW_W = 8,
  parameter bit SPARSE = 1'b0
) (
  input  logic            hit,
  input  logic            t_cyc,
  input  logic            t_stb,
  input  logic            t_we,
  input  logic [AW-1:0]   offset,
  input  logic [DW-1:0]   t_dat_w,
  input  logic [DW/GRAN-1:0] t_sel,
  output logic [AW-1:0]   s_adr,
  output logic [DW-1:0]   s_dat_w,
  output logic [DW/GRAN-1:0] s_sel,
  output logic            s_cyc,
  output logic            s_stb,
  output logic            s_we,
  input  logic [DW-1:0]   s_dat_r,
  output logic [DW-1:0]   lane_r
);
  localparam int SW = DW / GRAN;
  localparam int NSW = NARROW_W / GRAN;

  assign s_cyc = t_cyc & hit;
  assign s_stb = t_cyc & t_stb & hit;
  assign s_we  = t_we;
  assign s_adr = offset;

  if (SPARSE) begin : g_narrow
    localparam logic [DW-1:0] DMASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [SW-1:0] SMASK = {{(SW-NSW){1'b0}}, {NSW{1'b1}}};
    assign s_dat_w = t_dat_w & DMASK;
    assign s_sel   = t_sel & SMASK;
    assign lane_r  = s_dat_r & DMASK;
  end else begin : g_dense
    assign s_dat_w = t_dat_w;
    assign s_sel   = t_sel;
    assign lane_r  = s_dat_r;
  end
endmodule

// File: rtl/wbdec_resp.sv
module wbdec_resp #(
  parameter int N_SUB = 3,
  parameter int DW = 32,
  parameter bit HAS_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              t_cyc,
  input  logic              t_stb,
  input  logic [N_SUB-1:0]  hit,
  input  logic [N_SUB-1:0]  s_ack,
  input  logic [N_SUB-1:0]  s_err,
  input  logic [N_SUB*DW-1:0] lane_r,
  output logic              miss,
  output logic              t_ack,
  output logic              t_err,
  output logic [DW-1:0]     t_dat_r
);
  logic req;
  logic miss_err_q;

  assign req  = t_cyc & t_stb;
  assign miss = ~|hit;

  always_comb begin
    t_dat_r = '0;
    for (int i = 0; i < N_SUB; i++) begin
      if (hit[i]) t_dat_r = t_dat_r | lane_r[i*DW +: DW];
    end
  end

  if (HAS_ERR) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) miss_err_q <= 1'b0;
      else     miss_err_q <= req & miss & ~miss_err_q;
    end

    AST_MISS_ERR: assert property (@(posedge clk) disable iff (rst)
      (req && miss && !t_err) |=> t_err); // R6
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
      (miss && t_err) |=> !t_err); // R6
  end else begin : g_noerr
    assign miss_err_q = 1'b0;
  end

  assign t_ack = req & |(s_ack & hit);
  assign t_err = (req & |(s_err & hit)) | miss_err_q;

  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    miss |-> !t_ack); // R6
endmodule

// File: rtl/wb_window_decoder.sv
module wb_window_decoder
  import wbdec_pkg::*;
#(
  parameter int N_SUB = 3,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int GRAN = 8,
  parameter int NARROW_W = 8,
  parameter bit HAS_ERR = 1'b1,
  parameter logic [N_SUB*AW-1:0] WIN_BASE = {16'h1000, 16'h0100, 16'h0000},
  parameter logic [N_SUB*LOG2_W-1:0] WIN_LOG2 = {5'd12, 5'd4, 5'd8},
  parameter logic [N_SUB-1:0] WIN_SPARSE = 3'b010
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             t_adr,
  input  logic [DW-1:0]             t_dat_w,
  output logic [DW-1:0]             t_dat_r,
  input  logic [DW/GRAN-1:0]        t_sel,
  input  logic                      t_cyc,
  input  logic                      t_stb,
  input  logic                      t_we,
  output logic                      t_ack,
  output logic                      t_err,
  output logic [N_SUB*AW-1:0]       s_adr,
  output logic [N_SUB*DW-1:0]       s_dat_w,
  input  logic [N_SUB*DW-1:0]       s_dat_r,
  output logic [N_SUB*(DW/GRAN)-1:0] s_sel,
  output logic [N_SUB-1:0]          s_cyc,
  output logic [N_SUB-1:0]          s_stb,
  output logic [N_SUB-1:0]          s_we,
  input  logic [N_SUB-1:0]          s_ack,
  input  logic [N_SUB-1:0]          s_err
);
  localparam int SW = DW / GRAN;

  logic [N_SUB-1:0]    hit;
  logic [N_SUB*AW-1:0] offset;
  logic [N_SUB*DW-1:0] lane_r;
  logic                miss;

  wbdec_match #(
    .N_SUB(N_SUB), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
  ) match_i (
    .clk(clk), .rst(rst), .adr(t_adr), .hit(hit), .offset(offset)
  );

  for (genvar i = 0; i < N_SUB; i++) begin : g_lane
    wbdec_lane #(
      .AW(AW), .DW(DW), .GRAN(GRAN), .NARROW_W(NARROW_W),
      .SPARSE(WIN_SPARSE[i])
    ) lane_i (
      .hit(hit[i]),
      .t_cyc(t_cyc),
      .t_stb(t_stb),
      .t_we(t_we),
      .offset(offset[i*AW +: AW]),
      .t_dat_w(t_dat_w),
      .t_sel(t_sel),
      .s_adr(s_adr[i*AW +: AW]),
      .s_dat_w(s_dat_w[i*DW +: DW]),
      .s_sel(s_sel[i*SW +: SW]),
      .s_cyc(s_cyc[i]),
      .s_stb(s_stb[i]),
      .s_we(s_we[i]),
      .s_dat_r(s_dat_r[i*DW +: DW]),
      .lane_r(lane_r[i*DW +: DW])
    );
  end

  wbdec_resp #(
    .N_SUB(N_SUB), .DW(DW), .HAS_ERR(HAS_ERR)
  ) resp_i (
    .clk(clk), .rst(rst), .t_cyc(t_cyc), .t_stb(t_stb), .hit(hit),
    .s_ack(s_ack), .s_err(s_err), .lane_r(lane_r), .miss(miss),
    .t_ack(t_ack), .t_err(t_err), .t_dat_r(t_dat_r)
  );

  AST_CYC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_cyc)); // R2
  AST_MISS_NO_CYC: assert property (@(posedge clk) disable iff (rst)
    miss |-> (s_cyc == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !t_cyc |-> (s_stb == '0 && !t_ack)); // R7
endmodule

// File: tb/wb_window_decoder_tb.sv
module wb_window_decoder_tb_top;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] t_adr = '0;
  logic [31:0] t_dat_w = '0;
  logic [3:0]  t_sel = '0;
  logic        t_cyc = 1'b0, t_stb = 1'b0, t_we = 1'b0;
  logic [N*32-1:0] s_dat_r;
  logic [N-1:0] s_ack = '1, s_err = '0;

  logic [31:0] t_dat_r, t_dat_r2;
  logic        t_ack, t_err, t_ack2, t_err2;
  logic [N*16-1:0] s_adr, s_adr2;
  logic [N*32-1:0] s_dat_w, s_dat_w2;
  logic [N*4-1:0]  s_sel, s_sel2;
  logic [N-1:0]    s_cyc, s_stb, s_we, s_cyc2, s_stb2, s_we2;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign s_dat_r = {32'h3333_4444, 32'hDEAD_BE5A, 32'h1111_2222};

  wb_window_decoder dut_i (
    .clk, .rst, .t_adr, .t_dat_w, .t_dat_r, .t_sel, .t_cyc, .t_stb, .t_we,
    .t_ack, .t_err, .s_adr, .s_dat_w, .s_dat_r, .s_sel, .s_cyc, .s_stb,
    .s_we, .s_ack, .s_err
  );

  wb_window_decoder #(.HAS_ERR(1'b0)) dut_noerr_i (
    .clk, .rst, .t_adr, .t_dat_w, .t_dat_r(t_dat_r2), .t_sel, .t_cyc,
    .t_stb, .t_we, .t_ack(t_ack2), .t_err(t_err2), .s_adr(s_adr2),
    .s_dat_w(s_dat_w2), .s_dat_r, .s_sel(s_sel2), .s_cyc(s_cyc2),
    .s_stb(s_stb2), .s_we(s_we2), .s_ack, .s_err
  );

  typedef struct packed {
    logic [15:0] adr;
    logic        we;
    logic [3:0]  sel;
    logic [31:0] wdat;
    logic [1:0]  sub;   // 3 = no window
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 1'b1, 4'hF, 32'h1234_5678, 2'd0},
    '{16'h00FF, 1'b0, 4'h3, 32'h0000_0000, 2'd0},
    '{16'h0100, 1'b1, 4'hF, 32'hCAFE_BABE, 2'd1},
    '{16'h010F, 1'b1, 4'hE, 32'h7700_00AA, 2'd1},
    '{16'h0110, 1'b0, 4'hF, 32'h0000_0000, 2'd3},
    '{16'h1000, 1'b0, 4'hF, 32'h0000_0000, 2'd2},
    '{16'h1FFF, 1'b1, 4'h5, 32'h0BAD_F00D, 2'd2},
    '{16'h2000, 1'b0, 4'hF, 32'h0000_0000, 2'd3},
    '{16'h0200, 1'b1, 4'hF, 32'h5555_AAAA, 2'd3}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [15:0] win_mask(input int s);
    return (s == 0) ? 16'h00FF : (s == 1) ? 16'h000F : 16'h0FFF;
  endfunction

  function automatic logic [31:0] win_rdata(input int s);
    return (s == 0) ? 32'h1111_2222 : (s == 1) ? 32'h0000_005A : 32'h3333_4444;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #5;
    chk("R8 err low in reset", {31'd0, t_err}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #5;
    chk("R8 err low after reset", {31'd0, t_err}, 32'd0);
    chk("R8 no sub cycle after reset", {29'd0, s_cyc}, 32'd0);

    // Table walk: R1 R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      t_adr = TBL[v].adr; t_we = TBL[v].we; t_sel = TBL[v].sel;
      t_dat_w = TBL[v].wdat; t_cyc = 1'b1; t_stb = 1'b1;
      #5;
      if (TBL[v].sub == 2'd3) begin
        chk("R6 miss no sub cyc", {29'd0, s_cyc}, 32'd0);
        chk("R6 miss no ack", {31'd0, t_ack}, 32'd0);
        chk("R6 miss err not yet", {31'd0, t_err}, 32'd0);
      end else begin
        int s;
        s = int'(TBL[v].sub);
        chk("R1 R2 cyc onehot", {29'd0, s_cyc}, 32'd1 << s);
        chk("R1 stb onehot", {29'd0, s_stb}, 32'd1 << s);
        chk("R1 offset", {16'd0, s_adr[s*16 +: 16]}, {16'd0, TBL[v].adr & win_mask(s)});
        chk("R3 R4 we", {31'd0, s_we[s]}, {31'd0, TBL[v].we});
        if (s == 1) begin
          chk("R4 narrow wdat", s_dat_w[s*32 +: 32], {24'd0, TBL[v].wdat[7:0]});
          chk("R4 narrow sel", {28'd0, s_sel[s*4 +: 4]}, {31'd0, TBL[v].sel[0]});
        end else begin
          chk("R3 dense wdat", s_dat_w[s*32 +: 32], TBL[v].wdat);
          chk("R3 dense sel", {28'd0, s_sel[s*4 +: 4]}, {28'd0, TBL[v].sel});
        end
        chk("R3 R4 rdata", t_dat_r, win_rdata(s));
        chk("R5 ack from selected", {31'd0, t_ack}, 32'd1);
      end
      @(negedge clk);
      #5;
      chk("R6 err one cycle after miss", {31'd0, t_err}, {31'd0, TBL[v].sub == 2'd3});
      t_cyc = 1'b0; t_stb = 1'b0;
    end

    // R5: unselected ack/err ignored
    @(negedge clk);
    s_ack = 3'b101; s_err = 3'b101;
    t_adr = 16'h0105; t_cyc = 1'b1; t_stb = 1'b1; t_we = 1'b0;
    #5;
    chk("R5 foreign ack ignored", {31'd0, t_ack}, 32'd0);
    chk("R5 foreign err ignored", {31'd0, t_err}, 32'd0);
    s_err = 3'b010;
    #2;
    chk("R5 selected err routed", {31'd0, t_err}, 32'd1);
    s_err = 3'b000; s_ack = 3'b010;
    #2;
    chk("R5 selected ack routed", {31'd0, t_ack}, 32'd1);
    s_ack = 3'b111;

    // R7: stb without cyc
    @(negedge clk);
    t_cyc = 1'b0; t_stb = 1'b1; t_adr = 16'h0010;
    #5;
    chk("R7 no sub cyc", {29'd0, s_cyc}, 32'd0);
    chk("R7 no sub stb", {29'd0, s_stb}, 32'd0);
    chk("R7 no ack", {31'd0, t_ack}, 32'd0);
    t_stb = 1'b0;

    // R6 pulse width and R9 on the no-err instance: hold a miss
    @(negedge clk);
    t_adr = 16'h3000; t_cyc = 1'b1; t_stb = 1'b1;
    @(negedge clk);
    #5;
    chk("R6 err high", {31'd0, t_err}, 32'd1);
    @(negedge clk);
    #5;
    chk("R6 err single cycle", {31'd0, t_err}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #5;
      chk("R9 no err without err option", {31'd0, t_err2}, 32'd0);
      chk("R9 no ack without err option", {31'd0, t_ack2}, 32'd0);
    end
    t_cyc = 1'b0; t_stb = 1'b0;

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule